// File: doc/BRIEF.md
# Crossbar-Routed Wide-Instruction Datapath

This block is a small, statically scheduled datapath. Its function units sit side by side, and each unit input has its own source multiplexer. Each clock cycle the block fetches one wide instruction word from an external instruction memory. That single word sets the operation of every unit and, for every unit input, selects which unit output feeds it. There is no register file and no pipeline control. The compiler decides every route and every operation, cycle by cycle.

The default build has four outputs, indexed in this order:

- index 0: adder/subtractor 0
- index 1: adder/subtractor 1
- index 2: the constant loader
- index 3: a hold register that copies any output

All unit outputs are registered. A value produced in one cycle can be read by any input in the next cycle. All outputs are exposed on a debug tap bus, so the bench and the surrounding logic can observe them.

Top module: `vliw_xbar_core`

## Requirements
- R1: While reset is high, all four outputs are cleared to zero and the instruction address is 0 on the next clock edge.
- R2: Outside reset, the instruction address increases by one on every clock edge. It wraps from 2^ADDR_W-1 to 0.
- R3: When an adder's mode bit is 0, its output becomes A + B modulo 2^32. A and B are the values of the outputs named by its two source fields.
- R4: When an adder's mode bit is 1, its output becomes A - B modulo 2^32.
- R5: Instruction layout, LSB first. For adder i the word holds a 5-bit field at bit 5*i:
  - bits 1:0 select source A;
  - bits 3:2 select source B;
  - bit 4 is the mode bit.
  The hold source is at bits 11:10. The constant is at bits 43:12. A source value k selects output index k (0 and 1 are the adders, 2 the constant loader, 3 the hold register).
- R6: Outputs change only at the clock edge. An input read in cycle N sees the output values left by cycle N-1.
- R7: The constant loader output becomes bits 43:12 of the instruction executed in the previous cycle.
- R8: The hold register output becomes the value of the output selected by its source field.
- R9: Both adders compute in the same cycle, each with its own sources and mode.
- R10: A unit may select its own output as a source, so a self-routed adder accumulates from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | ADDR_W (6) | Instruction memory read address |
| imemData | input | 44 | Instruction word at imemAddr, combinational read |
| dbgTaps | output | 128 | Output k on bits 32*k+31:32*k |

## Verification
The bench sweeps every combination of source fields and mode bits for adder 0, with a varied pattern on adder 1 and the hold register. It checks each output every cycle against an arithmetic model.

The constants include all-ones and the sign bit, so carries and borrows must wrap at 32 bits. A design that extended the result width or mixed up the A and B operands of a subtract shows up immediately.

The program runs past the end of the address space. A design that saturated or mis-sized the counter would replay the wrong instructions.

A mid-run reset and a self-accumulating program come next. They expose a mux that read the current cycle's results instead of the registered ones, and a hold register that did not clear.

// File: rtl/vxc_pkg.sv
package vxc_pkg;
  localparam int DATA_W      = 32;
  localparam int NUM_ADD     = 2;
  localparam int NUM_OUT     = NUM_ADD + 2;
  localparam int SEL_W       = $clog2(NUM_OUT);
  localparam int LIT_IDX     = NUM_ADD;
  localparam int HOLD_IDX    = NUM_ADD + 1;
  localparam int ADD_FIELD_W = 2 * SEL_W + 1;
  localparam int HOLD_LSB    = NUM_ADD * ADD_FIELD_W;
  localparam int LIT_LSB     = HOLD_LSB + SEL_W;
  localparam int INSTR_W     = LIT_LSB + DATA_W;

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    sel_t selA;
    sel_t selB;
    logic doSub;
  } addCtl_t;

  typedef struct packed {
    addCtl_t [NUM_ADD-1:0] add;
    sel_t                  holdSel;
    word_t                 litValue;
  } ctrl_t;
endpackage

// File: rtl/vxc_ctrl.sv
module vxc_ctrl
  import vxc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output ctrl_t              ctl
);
  logic [ADDR_W-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc + 1'b1;
  end

  assign imemAddr = pc;

  for (genvar g = 0; g < NUM_ADD; g++) begin : g_dec
    localparam int BASE = g * ADD_FIELD_W;
    assign ctl.add[g].selA  = imemData[BASE +: SEL_W];
    assign ctl.add[g].selB  = imemData[BASE + SEL_W +: SEL_W];
    assign ctl.add[g].doSub = imemData[BASE + 2*SEL_W];
  end

  assign ctl.holdSel  = imemData[HOLD_LSB +: SEL_W];
  assign ctl.litValue = imemData[LIT_LSB +: DATA_W];

  // R2: fetch address steps by one each cycle, wrapping naturally
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> imemAddr == ADDR_W'($past(imemAddr) + 1'b1));
endmodule

// File: rtl/vxc_dpath.sv
module vxc_dpath
  import vxc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  ctrl_t               ctl,
  output word_t [NUM_OUT-1:0] taps
);
  word_t [NUM_OUT-1:0] outReg;
  word_t [NUM_ADD-1:0] opA;
  word_t [NUM_ADD-1:0] opB;
  word_t               holdIn;

  // Crossbar: every input reads last cycle's registered outputs (R6)
  for (genvar g = 0; g < NUM_ADD; g++) begin : g_add
    assign opA[g] = outReg[ctl.add[g].selA];
    assign opB[g] = outReg[ctl.add[g].selB];

    always_ff @(posedge clk) begin
      if (rst)                    outReg[g] <= '0;
      else if (ctl.add[g].doSub)  outReg[g] <= opA[g] - opB[g];
      else                        outReg[g] <= opA[g] + opB[g];
    end

    p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
      !ctl.add[g].doSub |=> outReg[g] == word_t'($past(opA[g]) + $past(opB[g])));
    p_sub_diff_r4: assert property (@(posedge clk) disable iff (rst)
      ctl.add[g].doSub |=> outReg[g] == word_t'($past(opA[g]) - $past(opB[g])));
  end

  assign holdIn = outReg[ctl.holdSel];

  always_ff @(posedge clk) begin
    if (rst) begin
      outReg[LIT_IDX]  <= '0;
      outReg[HOLD_IDX] <= '0;
    end else begin
      outReg[LIT_IDX]  <= ctl.litValue;
      outReg[HOLD_IDX] <= holdIn;
    end
  end

  assign taps = outReg;

  p_lit_load_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> outReg[LIT_IDX] == $past(ctl.litValue));
  p_hold_copy_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> outReg[HOLD_IDX] == $past(holdIn));
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> outReg == '0);
endmodule

// File: rtl/vliw_xbar_core.sv
module vliw_xbar_core
  import vxc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  output logic [ADDR_W-1:0]         imemAddr,
  input  logic [INSTR_W-1:0]        imemData,
  output logic [NUM_OUT*DATA_W-1:0] dbgTaps
);
  ctrl_t               ctl;
  word_t [NUM_OUT-1:0] taps;

  vxc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .imemAddr (imemAddr),
    .imemData (imemData),
    .ctl      (ctl)
  );

  vxc_dpath u_dpath (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ctl),
    .taps (taps)
  );

  assign dbgTaps = taps;
endmodule

// File: tb/vliw_xbar_core_bench.sv
`timescale 1ns/1ps
module vliw_xbar_core_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] imemAddr;
  logic [43:0]   imemData;
  logic [127:0]  dbgTaps;
  logic [43:0]   mem [DEPTH];

  int checks = 0;
  int fails  = 0;

  logic [31:0] expOut [4];
  logic [AW-1:0] expPc;
  logic expSub [2];

  always #2.5 clk = ~clk;

  assign imemData = mem[imemAddr];

  vliw_xbar_core #(.ADDR_W(AW)) u_vliw_xbar_core (
    .clk(clk), .rst(rst), .imemAddr(imemAddr),
    .imemData(imemData), .dbgTaps(dbgTaps)
  );

  function automatic logic [31:0] tap(input int i);
    return dbgTaps[i*32 +: 32];
  endfunction

  // Layout per R5: adder i at 5*i {sub, selB, selA}, hold 11:10, constant 43:12
  function automatic logic [43:0] mk(input int a0A, input int a0B, input int a0S,
                                     input int a1A, input int a1B, input int a1S,
                                     input int hs, input logic [31:0] lit);
    logic [43:0] w = '0;
    w[1:0] = 2'(a0A); w[3:2] = 2'(a0B); w[4] = 1'(a0S);
    w[6:5] = 2'(a1A); w[8:7] = 2'(a1B); w[9] = 1'(a1S);
    w[11:10] = 2'(hs); w[43:12] = lit;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 4; i++) expOut[i] = '0;
    expPc = '0;
    expSub[0] = 1'b0; expSub[1] = 1'b0;
  endtask

  // Arithmetic model of one clock edge (R3, R4, R6, R7, R8, R9)
  task automatic modelStep();
    logic [43:0] w = mem[expPc];
    logic [31:0] nxt [4];
    for (int a = 0; a < 2; a++) begin
      logic [31:0] va = expOut[w[a*5 +: 2]];
      logic [31:0] vb = expOut[w[a*5+2 +: 2]];
      nxt[a] = w[a*5+4] ? va - vb : va + vb;
      expSub[a] = w[a*5+4];
    end
    nxt[2] = w[43:12];
    nxt[3] = expOut[w[11:10]];
    for (int i = 0; i < 4; i++) expOut[i] = nxt[i];
    expPc = expPc + 1'b1;
  endtask

  task automatic checkAll();
    chk("R2", 32'(imemAddr), 32'(expPc));
    for (int a = 0; a < 2; a++)
      chk(expSub[a] ? "R4/R9" : "R3/R9", tap(a), expOut[a]);
    chk("R7", tap(2), expOut[2]);
    chk("R5/R8", tap(3), expOut[3]);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // Program A: sweep all adder-0 source/mode combinations (R5)
    for (int k = 0; k < DEPTH; k++) begin
      logic [31:0] lit = 32'(k) * 32'h9E3779B9 ^ ((k % 2) ? 32'hFFFF0000 : 32'h0);
      if (k == 5) lit = 32'hFFFF_FFFF;
      if (k == 6) lit = 32'h8000_0000;
      if (k == 9) lit = 32'h0;
      mem[k] = mk(k % 4, (k / 4) % 4, (k / 16) % 2,
                  3 - (k % 4), (k / 2) % 4, (k / 32) % 2,
                  (k + 1) % 4, lit);
    end
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 4; i++) chk("R1", tap(i), 32'h0);
    chk("R1", 32'(imemAddr), 32'h0);
    rst = 1'b0;
    for (int n = 0; n < 2 * DEPTH + 12; n++) begin
      checkAll();
      if (n == 1) chk("R6", tap(2), mem[0][43:12]);
      modelStep();
      @(negedge clk);
    end

    // Mid-run reset, then Program B: self-accumulation (R10)
    rst = 1'b1;
    for (int k = 0; k < DEPTH; k++)
      mem[k] = mk(0, 2, 0, 1, 2, 1, 0, 32'd3);
    @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R1", tap(i), 32'h0);
    chk("R1", 32'(imemAddr), 32'h0);
    modelReset();
    rst = 1'b0;
    for (int n = 0; n < 24; n++) begin
      checkAll();
      if (n >= 1) begin
        chk("R10", tap(0), 32'(3 * (n - 1)));
        chk("R10", tap(1), 32'(-3 * (n - 1)));
      end
      if (n >= 2) chk("R10", tap(3), 32'(3 * (n - 2)));
      modelStep();
      @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule